// File: doc/BRIEF.md
# Two-Pair PWM Generator with H-Bridge Steering

This block produces four pulse-width modulated outputs from two channel pairs. Each pair has its own up-counter and one active period value. Each output in a pair has its own active compare value. Software writes new compare and period values into buffer registers through a simple synchronous write/read port. These values reach the active registers only when software raises a load request, and only at a pair's period boundary, so a partly updated period is never output.

A steering mode is meant for driving an H-bridge. In that mode a direction bit picks which pair of outputs carries the waveform, and the other pair is held low. A master enable gates all outputs. An external trip input, once armed, latches a fault flag that forces every output low until software clears it. Each output also latches an interrupt flag on its compare match. Software clears these flags by writing ones to a clear register.

Top module: `pwm_hbridge`

## Requirements
- R1: Writing the buffer registers (pair p at address 4+4p: compare A at +0, compare B at +1, period at +2) does not change the waveform while no load is requested.
- R2: With steering mode off, a load request (control bit 3) copies each pair's buffered values into its active registers when that pair's counter wraps, or at once while the master enable is off. The bit clears itself once both pairs have copied.
- R3: With steering mode on (control bit 1), the load request bit stays set. Every period boundary then copies the buffer, so later buffer writes take effect without a new request.
- R4: With steering mode on, direction (control bit 2) = 0 holds outputs 0 and 1 low, and direction = 1 holds outputs 2 and 3 low.
- R5: Master enable (control bit 0) = 0 holds all four outputs low and stops the counters at 0.
- R6: Trip enable (bit 0 at address 1) arms the trip input. An armed, asserted trip input sets flag bit 4 and forces all outputs low from the next cycle until software clears that flag. Without the arm, the trip input has no effect.
- R7: Flag bit k (k = 0..3) latches when output k's compare value equals its pair's count while running. Writing 1 to bit k at address 2 clears flag k. Address 2 always reads 0, and address 3 reads the flags.
- R8: After reset the control register reads 0x2 (steering on). Trip enable, flags, the buffer registers and the active registers are all 0.
- R9: Each pair's counter runs from 0 up to its active period and wraps to 0. An output is high while the count is below its active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| trip_in | input | 1 | External fault input |
| pwm_out | output | 4 | PWM outputs 0 to 3 |
| irq | output | 5 | Latched flags: bits 0-3 per output, bit 4 trip |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a 4-bit address. It programs periods of 9, so each period lasts ten cycles and several whole periods fit in short sampling windows. Because every window spans a whole number of periods, the high-cycle counts do not depend on phase. Duty ratios, the effect of a load request, steering in both directions and trip masking can therefore be checked by counting high cycles. Compare values of 0 or above the period, and counts near the 16-bit limit, are not exercised.

// File: rtl/pwm_hb_pkg.sv
// Shared definitions for the H-bridge PWM unit: register map and control layout.
// Assumes a word-addressed register port where each address holds one 16-bit value.
package pwm_hb_pkg;

    // control register fields, MSB first: load request, direction, steering, enable
    typedef struct packed {
        logic load;
        logic dir;
        logic hb;
        logic en;
    } ctrl_t;

    localparam int A_CTRL      = 0;
    localparam int A_TRIPCFG   = 1;
    localparam int A_FLAGCLR   = 2;
    localparam int A_FLAGS     = 3;
    localparam int A_PAIR_BASE = 4;
    localparam int PAIR_STRIDE = 4;
    localparam int OFF_CMPA    = 0;
    localparam int OFF_CMPB    = 1;
    localparam int OFF_PER     = 2;

endpackage

// File: rtl/pwm_pair.sv
// One channel pair: a period counter shared by two outputs, with active
// compare and period registers that take buffered values at a period boundary.
// Assumes load_req stays high until software or the register block drops it.
module pwm_pair #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load_req,
    input  logic [CNT_W-1:0] shd_cmp_a,
    input  logic [CNT_W-1:0] shd_cmp_b,
    input  logic [CNT_W-1:0] shd_per,
    output logic [1:0]       raw,
    output logic [1:0]       match,
    output logic             loaded
);

    logic [CNT_W-1:0]      cnt_q;
    logic [CNT_W-1:0]      per_q;
    logic [1:0][CNT_W-1:0] cmp_q;
    logic                  at_end;

    assign at_end = (cnt_q == per_q);
    // an idle counter sits at a boundary on every cycle
    assign loaded = load_req && (!run || at_end);

    // period counter: 0..per, held at 0 while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (at_end)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // active register update only at a boundary with a request pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            cmp_q <= '0;
        end else if (loaded) begin
            per_q    <= shd_per;
            cmp_q[0] <= shd_cmp_a;
            cmp_q[1] <= shd_cmp_b;
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_out
        assign raw[k]   = run && (cnt_q < cmp_q[k]);
        assign match[k] = run && (cnt_q == cmp_q[k]);
    end

endmodule

// File: rtl/pwm_regs.sv
// Register block: control, trip arm, write-one-to-clear flags and buffer registers.
// Assumes single-cycle writes; reads are combinational from addr.
module pwm_regs
    import pwm_hb_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 4,
    parameter int N_PAIRS = 2,
    localparam int N_OUT  = 2 * N_PAIRS,
    localparam int N_FLAG = N_OUT + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CNT_W-1:0]               wdata,
    output logic [CNT_W-1:0]               rdata,
    input  logic                           trip_in,
    input  logic [N_PAIRS-1:0]             loaded,
    input  logic [N_OUT-1:0]               match,
    output ctrl_t                          ctrl,
    output logic [N_PAIRS-1:0][CNT_W-1:0]  shd_a,
    output logic [N_PAIRS-1:0][CNT_W-1:0]  shd_b,
    output logic [N_PAIRS-1:0][CNT_W-1:0]  shd_per,
    output logic [N_FLAG-1:0]              flags
);

    logic               wr_ctrl, wr_trip, wr_clr;
    logic               trip_en_q;
    logic [N_PAIRS-1:0] done_q;
    logic               all_done;
    logic               self_clear;
    logic [N_FLAG-1:0]  set_v, clr_v;

    assign wr_ctrl    = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_trip    = wr_en && (addr == ADDR_W'(A_TRIPCFG));
    assign wr_clr     = wr_en && (addr == ADDR_W'(A_FLAGCLR));
    assign all_done   = &(done_q | loaded);
    assign self_clear = ctrl.load && !ctrl.hb;

    // control register; a software write wins over the self-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl <= '{load: 1'b0, dir: 1'b0, hb: 1'b1, en: 1'b0};
        else if (wr_ctrl)                ctrl <= ctrl_t'(wdata[3:0]);
        else if (self_clear && all_done) ctrl.load <= 1'b0;
    end

    // per-pair record of copies made since the request in standard mode
    always_ff @(posedge clk) begin
        if (!rst_n)                      done_q <= '0;
        else if (wr_ctrl || !self_clear) done_q <= '0;
        else if (all_done)               done_q <= '0;
        else                             done_q <= done_q | loaded;
    end

    // trip arm bit
    always_ff @(posedge clk) begin
        if (!rst_n)       trip_en_q <= 1'b0;
        else if (wr_trip) trip_en_q <= wdata[0];
    end

    assign set_v = {trip_en_q && trip_in, match};
    assign clr_v = wr_clr ? wdata[N_FLAG-1:0] : '0;

    // latched flags; a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_shd
        localparam int BASE = A_PAIR_BASE + p * PAIR_STRIDE;
        logic [CNT_W-1:0] a_q, b_q, per_q;

        // buffer registers of pair p
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q   <= '0;
                b_q   <= '0;
                per_q <= '0;
            end else if (wr_en) begin
                if (addr == ADDR_W'(BASE + OFF_CMPA)) a_q   <= wdata;
                if (addr == ADDR_W'(BASE + OFF_CMPB)) b_q   <= wdata;
                if (addr == ADDR_W'(BASE + OFF_PER))  per_q <= wdata;
            end
        end

        assign shd_a[p]   = a_q;
        assign shd_b[p]   = b_q;
        assign shd_per[p] = per_q;
    end

    // read multiplexer; the clear register reads as zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))    rdata = CNT_W'(ctrl);
        if (addr == ADDR_W'(A_TRIPCFG)) rdata = CNT_W'(trip_en_q);
        if (addr == ADDR_W'(A_FLAGS))   rdata = CNT_W'(flags);
        for (int p = 0; p < N_PAIRS; p++) begin
            if (addr == ADDR_W'(A_PAIR_BASE + p * PAIR_STRIDE + OFF_CMPA)) rdata = shd_a[p];
            if (addr == ADDR_W'(A_PAIR_BASE + p * PAIR_STRIDE + OFF_CMPB)) rdata = shd_b[p];
            if (addr == ADDR_W'(A_PAIR_BASE + p * PAIR_STRIDE + OFF_PER))  rdata = shd_per[p];
        end
    end

endmodule

// File: rtl/pwm_steer.sv
// Output gating: master enable, trip masking and H-bridge pair steering.
// Assumes exactly two pairs, with outputs 0/1 in pair 0 and outputs 2/3 in pair 1.
module pwm_steer (
    input  logic [3:0] raw,
    input  logic       en,
    input  logic       hb,
    input  logic       dir,
    input  logic       tripped,
    output logic [3:0] pwm_out
);

    logic [3:0] mask;

    // select the driving pair in steering mode, otherwise pass all four
    always_comb begin
        if (!hb)      mask = 4'b1111;
        else if (dir) mask = 4'b0011;
        else          mask = 4'b1100;
        pwm_out = (en && !tripped) ? (raw & mask) : 4'b0000;
    end

endmodule

// File: rtl/pwm_hbridge.sv
// Top of the PWM unit: register block, two channel pairs and output steering.
// Assumes the register port is driven synchronously to clk.
module pwm_hbridge
    import pwm_hb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              trip_in,
    output logic [3:0]        pwm_out,
    output logic [4:0]        irq
);

    localparam int N_PAIRS = 2;

    ctrl_t                         ctrl_q;
    logic [N_PAIRS-1:0][CNT_W-1:0] shd_a, shd_b, shd_per;
    logic [N_PAIRS-1:0]            loaded;
    logic [2*N_PAIRS-1:0]          raw, match;

    pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .N_PAIRS(N_PAIRS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .trip_in(trip_in), .loaded(loaded), .match(match),
        .ctrl(ctrl_q), .shd_a(shd_a), .shd_b(shd_b), .shd_per(shd_per), .flags(irq)
    );

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        pwm_pair #(.CNT_W(CNT_W)) u_pair (
            .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .load_req(ctrl_q.load),
            .shd_cmp_a(shd_a[p]), .shd_cmp_b(shd_b[p]), .shd_per(shd_per[p]),
            .raw(raw[2*p +: 2]), .match(match[2*p +: 2]), .loaded(loaded[p])
        );
    end

    pwm_steer u_steer (
        .raw(raw), .en(ctrl_q.en), .hb(ctrl_q.hb), .dir(ctrl_q.dir),
        .tripped(irq[4]), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/pwm_hb_chk.sv
// Property checker for pwm_hbridge, attached by bind below.
// Assumes it sees the top's control register and ports.
module pwm_hb_chk
    import pwm_hb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              trip_in,
    input logic [3:0]        pwm_out,
    input logic [4:0]        irq,
    input ctrl_t             ctrl
);

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> pwm_out == 4'b0000);

    assert_trip_forces_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq[4] |-> pwm_out == 4'b0000);

    assert_trip_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[4]) |-> $past(trip_in));

    assert_steer_dir0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.hb && !ctrl.dir) |-> pwm_out[1:0] == 2'b00);

    assert_steer_dir1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.hb && ctrl.dir) |-> pwm_out[3:2] == 2'b00);

    assert_sticky_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.hb && ctrl.load && !(wr_en && addr == ADDR_W'(A_CTRL))) |=> ctrl.load);

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(A_FLAGCLR)) |=> ((irq & $past(irq)) == $past(irq)));

endmodule

bind pwm_hbridge pwm_hb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .trip_in(trip_in),
    .pwm_out(pwm_out), .irq(irq), .ctrl(ctrl_q)
);

// File: tb/pwm_hbridge_tb.sv
// Directed bench for pwm_hbridge: one task per scenario, each checking its own results.
module pwm_hbridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        trip_in = 1'b0;
    logic [3:0]  pwm_out;
    logic [4:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pwm_hbridge u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .trip_in(trip_in), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count high samples per output over n consecutive cycles
    task automatic meas(input int n, output int c [4]);
        for (int k = 0; k < 4; k++) c[k] = 0;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 4; k++) if (pwm_out[k]) c[k]++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int d;
        rd(4'd0, d);  chk("R8", "control", d, 2);
        rd(4'd1, d);  chk("R8", "trip arm", d, 0);
        rd(4'd3, d);  chk("R8", "flags", d, 0);
        rd(4'd10, d); chk("R8", "pair1 period buffer", d, 0);
        chk("R8", "outputs", int'(pwm_out), 0);
    endtask

    task automatic t_standard;
        int d;
        int c [4];
        wr(4'd4, 16'd3); wr(4'd5, 16'd5); wr(4'd6, 16'd9);
        wr(4'd8, 16'd2); wr(4'd9, 16'd7); wr(4'd10, 16'd9);
        rd(4'd10, d); chk("R8", "buffer readback", d, 9);
        wr(4'd0, 16'h1);                        // enable, standard, no load
        meas(20, c);
        chk("R1", "out0 before load", c[0], 0);
        chk("R1", "out3 before load", c[3], 0);
        wr(4'd0, 16'h9);                        // enable + load
        idle(10);
        rd(4'd0, d); chk("R2", "load self-cleared", d, 1);
        meas(50, c);
        chk("R9", "out0 duty", c[0], 15);
        chk("R9", "out1 duty", c[1], 25);
        chk("R9", "out2 duty", c[2], 10);
        chk("R9", "out3 duty", c[3], 35);
        wr(4'd4, 16'd8);                        // buffer only
        idle(12);
        meas(20, c);
        chk("R1", "out0 unchanged without load", c[0], 6);
        wr(4'd0, 16'h9);
        idle(25);
        rd(4'd0, d); chk("R2", "second load cleared", d, 1);
        meas(20, c);
        chk("R2", "out0 after wrap load", c[0], 16);
    endtask

    task automatic t_hbridge;
        int d;
        int c [4];
        wr(4'd0, 16'hB);                        // load, steering, dir 0, enable
        idle(25);
        rd(4'd0, d); chk("R3", "load bit sticky", d, 16'hB);
        meas(20, c);
        chk("R4", "dir0 out0 low", c[0], 0);
        chk("R4", "dir0 out1 low", c[1], 0);
        chk("R4", "dir0 out2", c[2], 4);
        chk("R4", "dir0 out3", c[3], 14);
        wr(4'd8, 16'd6);                        // buffer write, no new request
        idle(25);
        meas(20, c);
        chk("R3", "sticky reload out2", c[2], 12);
        wr(4'd0, 16'h7);                        // steering, dir 1, enable
        idle(2);
        meas(20, c);
        chk("R4", "dir1 out0", c[0], 16);
        chk("R4", "dir1 out1", c[1], 10);
        chk("R4", "dir1 out2 low", c[2], 0);
        chk("R4", "dir1 out3 low", c[3], 0);
    endtask

    task automatic t_disable_flags;
        int d;
        int c [4];
        wr(4'd0, 16'h0);
        meas(20, c);
        chk("R5", "all outputs off", c[0] + c[1] + c[2] + c[3], 0);
        rd(4'd3, d); chk("R7", "match flags latched", d, 15);
        rd(4'd2, d); chk("R7", "clear register reads 0", d, 0);
        wr(4'd2, 16'h1);
        rd(4'd3, d); chk("R7", "flag 0 cleared only", d, 14);
        wr(4'd2, 16'hE);
        rd(4'd3, d); chk("R7", "all flags cleared", d, 0);
    endtask

    task automatic t_trip;
        int d;
        int c [4];
        wr(4'd0, 16'h1);
        @(negedge clk); trip_in = 1'b1;
        idle(3);
        trip_in = 1'b0;
        rd(4'd3, d); chk("R6", "unarmed trip no flag", (d >> 4) & 1, 0);
        meas(20, c);
        chk("R6", "unarmed trip outputs run", c[3], 14);
        wr(4'd1, 16'h1);
        trip_in = 1'b1;
        @(negedge clk);
        chk("R6", "trip flag next cycle", int'(irq[4]), 1);
        chk("R6", "outputs off next cycle", int'(pwm_out), 0);
        trip_in = 1'b0;
        meas(20, c);
        chk("R6", "outputs stay off", c[0] + c[1] + c[2] + c[3], 0);
        wr(4'd2, 16'h10);
        rd(4'd3, d); chk("R6", "trip flag cleared", (d >> 4) & 1, 0);
        meas(20, c);
        chk("R6", "outputs resume", c[3], 14);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_standard();
        t_hbridge();
        t_disable_flags();
        t_trip();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule